// File: doc/BRIEF.md
# Banked Register SPI Access Engine

This engine sits between on-chip logic and an external SPI peripheral whose control registers are grouped into four switchable banks plus an area that every bank can see. A requester hands over one register operation at a time: a 16-bit register identifier, a direction, a width flag and write data. The identifier's upper byte names the bank (0 for the shared area, 1 to 4 for banks 0 to 3). Its lower byte holds the register address, of which bits 4:0 are used. The engine turns each request into one or more SPI transactions in mode 0 and returns read data with a single-cycle completion pulse.

The engine remembers which bank the peripheral is currently on. It only emits bank-select traffic when a banked register in a different bank is addressed. Bank changes use bit-set and bit-clear commands on the two select bits (bits 1:0) of the shared control register at address 0x1F. Reads of registers in the MAC/MII class take one extra byte, because the peripheral returns a dummy byte first. Sixteen-bit requests are carried out as two byte accesses.

Top module: `bank_spi_engine`

## Requirements
- R1: After reset cs_n is high, sclk is low, req_ready is high and done is low; the remembered bank is invalid, so the first banked request always performs a bank change.
- R2: A bank code of 0, or any code above 4, addresses the shared area and produces no bank-select transaction.
- R3: A banked request whose bank code equals the remembered bank produces no bank-select transaction; after a change the remembered bank becomes the requested code.
- R4: Each change is a fixed sequence on control register 0x1F with the mask in the data byte. Target bank 0 is one clear of 0x03. Target bank 3 is one set of 0x03. Target bank 1 is set 0x01 then clear 0x02. Target bank 2 is clear 0x01 then set 0x02.
- R5: Every command byte is opcode in bits 7:5 and register address in bits 4:0. The opcodes are read 000, write 010, bit-set 100 and bit-clear 101.
- R6: A read is 3 bytes for bank code 3 with address at most 0x1A, and for bank code 4 with address at most 0x05 or equal to 0x0A. Every other read is 2 bytes. Bytes after the command are sent as 0x00, and the read value is the last byte received.
- R7: A write, and each bank-select command, is exactly 2 bytes: command byte then data byte.
- R8: A wide request accesses the address first with the low data byte, then address+1 with the high byte, with a single bank check. Wide reads return {high, low} on rd_data, and narrow reads return the byte in rd_data[7:0] with bits 15:8 zero.
- R9: SPI mode 0 is used: sclk idles low, MOSI is sent MSB first and changes only while sclk is low, and MISO is sampled on the rising edge. cs_n stays low across a whole transaction and is high for at least one clock between transactions.
- R10: req_ready is high only when the engine is idle, and a request is taken when req_valid and req_ready are both high. done is a one-cycle pulse raised after the last transaction has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access over two registers |
| req_id | input | 16 | Bank code in bits 15:8, register address in bits 4:0 |
| req_wdata | input | 16 | Write data, low byte first |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data to peripheral |
| cs_n | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data from peripheral |

## Verification
The bench decodes every SPI transaction and replays a model of the bank cache. Every ordered pair of bank codes is swept, so that changes to each target bank, repeats of the same bank and shared-area accesses each show up in the transaction list. Reads over every address of banks 2 and 3 separate 3-byte transfers from 2-byte ones at the class edges. The peripheral model answers with a byte that depends on the transaction and byte index, so a wrong "last byte" choice shows up directly. Wide accesses whose two halves fall in different read classes check the address+1 step and the byte order in rd_data.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam logic [2:0] OP_RD   = 3'b000;
  localparam logic [2:0] OP_WR   = 3'b010;
  localparam logic [2:0] OP_BSET = 3'b100;
  localparam logic [2:0] OP_BCLR = 3'b101;
  localparam logic [4:0] CTRL_ADDR = 5'h1F;

  typedef enum logic [1:0] {S_IDLE, S_SW0, S_SW1, S_ACC} seq_t;
  typedef enum logic [1:0] {X_IDLE, X_SHIFT, X_GAP} xfer_t;

  function automatic logic [7:0] cmd_byte(input logic [2:0] op, input logic [4:0] a);
    return {op, a};
  endfunction

  function automatic logic long_read(input logic [7:0] code, input logic [4:0] a);
    return (code == 8'd3 && a <= 5'h1A) ||
           (code == 8'd4 && (a <= 5'h05 || a == 5'h0A));
  endfunction
endpackage

// File: rtl/bse_bank_plan.sv
module bse_bank_plan
  import bse_pkg::*;
(
  input  logic [1:0] target,
  output logic       two_ops,
  output logic [7:0] cmd0,
  output logic [7:0] mask0,
  output logic [7:0] cmd1,
  output logic [7:0] mask1
);
  localparam logic [7:0] SET_CMD = cmd_byte(OP_BSET, CTRL_ADDR);
  localparam logic [7:0] CLR_CMD = cmd_byte(OP_BCLR, CTRL_ADDR);

  always_comb begin
    two_ops = 1'b0;
    cmd1    = CLR_CMD;
    mask1   = 8'h00;
    case (target)
      2'd0: begin cmd0 = CLR_CMD; mask0 = 8'h03; end
      2'd1: begin cmd0 = SET_CMD; mask0 = 8'h01; two_ops = 1'b1; cmd1 = CLR_CMD; mask1 = 8'h02; end
      2'd2: begin cmd0 = CLR_CMD; mask0 = 8'h01; two_ops = 1'b1; cmd1 = SET_CMD; mask1 = 8'h02; end
      default: begin cmd0 = SET_CMD; mask0 = 8'h03; end
    endcase
  end
endmodule

// File: rtl/bse_spi_xfer.sv
module bse_spi_xfer
  import bse_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        long_xfer,
  input  logic [23:0] tx,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic        fin,
  output logic [7:0]  rx
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  xfer_t          st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [4:0]     bit_q, bit_d;
  logic [23:0]    sh_q, sh_d;
  logic [7:0]     rx_q, rx_d;
  logic           sclk_q, sclk_d, cs_q, cs_d, fin_q, fin_d, long_q, long_d;
  logic           half_done;
  logic [4:0]     last_bit;

  assign half_done = (cnt_q == CNT_LAST);
  assign last_bit  = long_q ? 5'd23 : 5'd15;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q; rx_d = rx_q;
    sclk_d = sclk_q; cs_d = cs_q; fin_d = 1'b0; long_d = long_q;
    case (st_q)
      X_IDLE: if (start) begin
        st_d = X_SHIFT; cs_d = 1'b0; sclk_d = 1'b0; sh_d = tx;
        bit_d = 5'd0; cnt_d = '0; long_d = long_xfer;
      end
      X_SHIFT: begin
        if (half_done) begin
          cnt_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[6:0], miso};
          end else begin
            sclk_d = 1'b0;
            if (bit_q == last_bit) begin
              st_d = X_GAP; cs_d = 1'b1;
            end else begin
              bit_d = bit_q + 5'd1;
              sh_d  = {sh_q[22:0], 1'b0};
            end
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        if (half_done) begin
          st_d = X_IDLE; fin_d = 1'b1; cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= X_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0; rx_q <= '0;
      sclk_q <= 1'b0; cs_q <= 1'b1; fin_q <= 1'b0; long_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; bit_q <= bit_d; sh_q <= sh_d; rx_q <= rx_d;
      sclk_q <= sclk_d; cs_q <= cs_d; fin_q <= fin_d; long_q <= long_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = sh_q[23];
  assign cs_n = cs_q;
  assign fin  = fin_q;
  assign rx   = rx_q;

  a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r9_mosi_steady_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/bank_spi_engine.sv
module bank_spi_engine
  import bse_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [15:0] req_id,
  input  logic [15:0] req_wdata,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso
);
  localparam logic [7:0] NO_BANK = 8'hFF;

  seq_t        st_q, st_d;
  logic        pend_q, pend_d, hi_q, hi_d, done_q, done_d;
  logic        wr_q, wr_d, wide_q, wide_d;
  logic [7:0]  code_q, code_d, cache_q, cache_d;
  logic [4:0]  addr_q, addr_d, addr_eff;
  logic [15:0] wdat_q, wdat_d, rd_q, rd_d;
  logic        x_start, x_long, x_fin, two_ops, banked_in;
  logic [23:0] x_tx;
  logic [7:0]  x_rx, cmd0, mask0, cmd1, mask1, wbyte;
  logic [1:0]  target;

  assign target    = 2'(code_q - 8'd1);
  assign addr_eff  = addr_q + 5'(hi_q);
  assign wbyte     = hi_q ? wdat_q[15:8] : wdat_q[7:0];
  assign banked_in = (req_id[15:8] >= 8'd1) && (req_id[15:8] <= 8'd4) &&
                     (req_id[15:8] != cache_q);
  assign x_start   = (st_q != S_IDLE) && !pend_q;
  assign x_long    = (st_q == S_ACC) && !wr_q && long_read(code_q, addr_eff);

  bse_bank_plan u_plan (
    .target(target), .two_ops(two_ops),
    .cmd0(cmd0), .mask0(mask0), .cmd1(cmd1), .mask1(mask1)
  );

  always_comb begin
    case (st_q)
      S_SW0:   x_tx = {cmd0, mask0, 8'h00};
      S_SW1:   x_tx = {cmd1, mask1, 8'h00};
      S_ACC:   x_tx = wr_q ? {cmd_byte(OP_WR, addr_eff), wbyte, 8'h00}
                           : {cmd_byte(OP_RD, addr_eff), 16'h0000};
      default: x_tx = 24'h0;
    endcase
  end

  bse_spi_xfer #(.HALF(HALF_CYCLES)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(x_start), .long_xfer(x_long), .tx(x_tx),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .fin(x_fin), .rx(x_rx)
  );

  always_comb begin
    st_d = st_q; pend_d = pend_q; hi_d = hi_q; done_d = 1'b0;
    wr_d = wr_q; wide_d = wide_q; code_d = code_q; cache_d = cache_q;
    addr_d = addr_q; wdat_d = wdat_q; rd_d = rd_q;
    if (x_start) pend_d = 1'b1;
    if (x_fin)   pend_d = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        wr_d = req_write; wide_d = req_wide; code_d = req_id[15:8];
        addr_d = req_id[4:0]; wdat_d = req_wdata; rd_d = 16'h0; hi_d = 1'b0;
        st_d = banked_in ? S_SW0 : S_ACC;
      end
      S_SW0: if (x_fin) begin
        if (two_ops) st_d = S_SW1;
        else begin st_d = S_ACC; cache_d = code_q; end
      end
      S_SW1: if (x_fin) begin
        st_d = S_ACC; cache_d = code_q;
      end
      default: if (x_fin) begin
        if (!wr_q) begin
          if (hi_q) rd_d[15:8] = x_rx;
          else      rd_d[7:0]  = x_rx;
        end
        if (wide_q && !hi_q) hi_d = 1'b1;
        else begin st_d = S_IDLE; done_d = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; pend_q <= 1'b0; hi_q <= 1'b0; done_q <= 1'b0;
      wr_q <= 1'b0; wide_q <= 1'b0; code_q <= 8'h0; cache_q <= NO_BANK;
      addr_q <= '0; wdat_q <= '0; rd_q <= '0;
    end else begin
      st_q <= st_d; pend_q <= pend_d; hi_q <= hi_d; done_q <= done_d;
      wr_q <= wr_d; wide_q <= wide_d; code_q <= code_d; cache_q <= cache_d;
      addr_q <= addr_d; wdat_q <= wdat_d; rd_q <= rd_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign done      = done_q;
  assign rd_data   = rd_q;

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  a_r2_switch_only_banked: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SW0) |-> (code_q >= 8'd1 && code_q <= 8'd4));
  a_r3_cache_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_q != NO_BANK) |-> (cache_q >= 8'd1 && cache_q <= 8'd4));
  a_r8_high_half_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q |-> wide_q);
endmodule

// File: tb/test_bank_spi_engine.sv
module test_bank_spi_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_id = '0, req_wdata = '0;
  logic req_ready, done, sclk, mosi, cs_n;
  logic miso = 1'b0;
  logic [15:0] rd_data;

  int checks = 0, failures = 0, cyc = 0;
  bit started = 0, finished = 0;

  always #4 clk = ~clk;

  bank_spi_engine #(.HALF_CYCLES(2)) i_bank_spi_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_id(req_id),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  function automatic logic [7:0] resp(input int g, input int b);
    return 8'h5A ^ {4'(g), 4'(b)};
  endfunction

  // peripheral model and transaction monitor
  int gtxn = 0, bp = 0, mon_n = 0;
  logic [23:0] sh = '0;
  logic [23:0] m_sh [8];
  int m_bits [8];

  always @(negedge cs_n) if (started) begin
    logic [7:0] r;
    bp = 0; sh = '0; r = resp(gtxn, 0); miso = r[7];
  end
  always @(posedge sclk) if (started && cs_n === 1'b0) begin
    sh = {sh[22:0], mosi}; bp++;
  end
  always @(negedge sclk) if (started && cs_n === 1'b0 && bp < 24) begin
    logic [7:0] r;
    r = resp(gtxn, bp / 8); miso = r[7 - (bp % 8)];
  end
  always @(posedge cs_n) if (started) begin
    if (mon_n < 8) begin m_sh[mon_n] = sh; m_bits[mon_n] = bp; end
    mon_n++; gtxn++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected transaction list
  int m_cache = 255;
  logic [7:0] e_cmd [8];
  logic [7:0] e_dat [8];
  int e_bits [8];
  bit e_rd [8];
  int e_n = 0;

  task automatic push(input logic [7:0] c, input logic [7:0] d, input int b, input bit rd);
    e_cmd[e_n] = c; e_dat[e_n] = d; e_bits[e_n] = b; e_rd[e_n] = rd; e_n++;
  endtask

  function automatic bit is_long(input int code, input logic [4:0] a);
    return (code == 3 && a <= 5'h1A) || (code == 4 && (a <= 5'h05 || a == 5'h0A));
  endfunction

  task automatic do_req(input bit wr, input bit wide, input int code,
                        input logic [4:0] a, input logic [15:0] wd, input string tag);
    int base_g, t;
    logic [15:0] exp_rd;
    e_n = 0; base_g = gtxn; exp_rd = 16'h0;
    // R4 R5: bank change model, bit-set = 0x9F, bit-clear = 0xBF
    if (code >= 1 && code <= 4 && code != m_cache) begin
      case (code - 1)
        0: push(8'hBF, 8'h03, 16, 0);
        1: begin push(8'h9F, 8'h01, 16, 0); push(8'hBF, 8'h02, 16, 0); end
        2: begin push(8'hBF, 8'h01, 16, 0); push(8'h9F, 8'h02, 16, 0); end
        default: push(8'h9F, 8'h03, 16, 0);
      endcase
      m_cache = code;
    end
    for (int k = 0; k <= int'(wide); k++) begin
      logic [4:0] ad;
      ad = a + 5'(k);
      if (wr) push({3'b010, ad}, k == 0 ? wd[7:0] : wd[15:8], 16, 0);
      else begin
        int nb;
        logic [7:0] rb;
        nb = is_long(code, ad) ? 3 : 2;
        push({3'b000, ad}, 8'h00, nb * 8, 1);
        rb = resp(base_g + e_n - 1, nb - 1);
        if (k == 0) exp_rd[7:0] = rb; else exp_rd[15:8] = rb;
      end
    end
    mon_n = 0;
    @(negedge clk);
    req_write = wr; req_wide = wide; req_id = {8'(code), 3'b000, a};
    req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready while busy", 32'(req_ready), 0);
    t = 0;
    while (done !== 1'b1 && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R10", "done seen", t, 0);
    chk(cs_n == 1'b1, "R9", "cs_n high at done", 32'(cs_n), 1);
    chk(mon_n == e_n, tag, "transaction count (R2 R3 R4)", mon_n, e_n);
    for (int i = 0; i < e_n && i < mon_n; i++) begin
      logic [7:0] c, d;
      chk(m_bits[i] == e_bits[i], tag, "bit count (R6 R7)", m_bits[i], e_bits[i]);
      c = (m_bits[i] == 24) ? m_sh[i][23:16] : m_sh[i][15:8];
      d = (m_bits[i] == 24) ? m_sh[i][15:8]  : m_sh[i][7:0];
      chk(c == e_cmd[i], tag, "R5 command byte", c, e_cmd[i]);
      chk(d == e_dat[i], tag, "second byte (R7 data / R6 dummy)", d, e_dat[i]);
      if (m_bits[i] == 24) chk(m_sh[i][7:0] == 8'h00, "R6", "third dummy byte", m_sh[i][7:0], 0);
    end
    if (!wr) chk(rd_data == exp_rd, tag, "read data (R6 R8)", rd_data, exp_rd);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", 32'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1; failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n after reset", 32'(cs_n), 1);
    chk(sclk == 1'b0, "R1", "sclk after reset", 32'(sclk), 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
    do_req(0, 0, 2, 5'h03, 16'h0, "R1");
    // R4 / R3 / R2: every ordered pair of bank codes
    for (int f = 1; f <= 4; f++)
      for (int t2 = 0; t2 <= 4; t2++) begin
        do_req(1, 0, f, 5'h04, 16'(8'hC0 + f * 5 + t2), "R4");
        do_req(0, 0, t2, 5'h06, 16'h0, "R4");
      end
    do_req(0, 0, 3, 5'h02, 16'h0, "R3");
    do_req(0, 0, 3, 5'h12, 16'h0, "R3");
    do_req(1, 0, 0, 5'h1B, 16'h0033, "R2");
    do_req(0, 0, 7, 5'h1C, 16'h0, "R2");
    // R6: read class sweep
    for (int c = 3; c <= 4; c++)
      for (int a = 0; a < 32; a++)
        do_req(0, 0, c, 5'(a), 16'h0, "R6");
    // R7: writes with varied data
    for (int c = 0; c <= 4; c++) begin
      do_req(1, 0, c, 5'h01, 16'h00A5, "R7");
      do_req(1, 0, c, 5'h1E, 16'h005A, "R7");
    end
    // R8: wide accesses, including halves in different read classes
    for (int c = 0; c <= 4; c++) begin
      do_req(1, 1, c, 5'h08, 16'hBEEF ^ 16'(c), "R8");
      do_req(0, 1, c, 5'h1A, 16'h0, "R8");
      do_req(0, 1, c, 5'h05, 16'h0, "R8");
      do_req(0, 1, c, 5'h04, 16'h0, "R8");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule